// File: doc/BRIEF.md
# Multi-scheme branch direction predictor

This block guesses whether a branch will be taken and hands the fetch stage the next address to fetch. A 3-bit mode input picks one of five schemes. Three are static: always fall through, always jump, or jump only when the target lies below the branch. Two are dynamic and share one table of 2-bit entries, indexed by low PC bits. That table holds either the last outcome of each branch or a saturating confidence counter per branch.

Lookup is purely combinational. The lookup port takes the branch PC and its decoded target, and returns the direction and the next fetch address in the same cycle. A separate resolve port reports the PC and the real outcome of an executed branch. In the dynamic modes this writes the matching table entry at the next clock edge. There is no tag check, so branches whose PCs share index bits share an entry.

Top module: `bdir_predictor`

## Requirements
- R1: Mode encoding on `mode_i`: 0 fall-through, 1 always-jump, 2 backward-jump, 3 last-outcome, 4 counter; codes 5 to 7 behave as code 0. In fall-through mode `pred_taken_o` is 0 and `next_pc_o` is `lk_pc_i + 4`.
- R2: In always-jump mode `pred_taken_o` is 1 and `next_pc_o` equals `lk_target_i`.
- R3: In backward-jump mode the prediction is taken exactly when `lk_target_i < lk_pc_i` as unsigned values. A target of 0x0040 from a branch at 0x00A0 is taken. A target equal to or above the PC is not taken.
- R4: Both dynamic modes use entry number `pc[IDX_W+1:2]`, for lookup and for resolve alike. PCs that differ only in other bits share an entry.
- R5: In last-outcome mode the prediction is bit 1 of the entry. A resolve writes the outcome into both bits of the entry, giving 11 for taken and 00 for not-taken.
- R6: In counter mode (00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken) the prediction is bit 1. A taken resolve increments the entry and stops at 11. A not-taken resolve decrements it and stops at 00.
- R7: Reset puts every entry at 00, so both dynamic modes predict not-taken for every PC after reset.
- R8: When a lookup and a resolve address the same entry in the same cycle, the lookup sees the value held before that resolve.
- R9: Resolves in modes 0, 1, 2 and 5 to 7 leave the table unchanged. Changing the mode never clears or alters the table.
- R10: In every mode `next_pc_o` is `lk_target_i` when `pred_taken_o` is 1, and `lk_pc_i + 4` otherwise.
- R11: From reset, a single entry that sees the outcomes T,T,T,T,NT, each predicted and resolved in the same cycle, yields 3 correct out of 5 in last-outcome mode. In counter mode it yields 2 out of 5 and ends at 10. A second pass in counter mode yields 4 out of 5, with only the final NT missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Scheme select |
| lk_pc_i | input | PC_W | PC of the branch being looked up |
| lk_target_i | input | PC_W | Decoded target of the looked-up branch |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| next_pc_o | output | PC_W | Next fetch address |
| rs_valid_i | input | 1 | A resolved branch is reported this cycle |
| rs_pc_i | input | PC_W | PC of the resolved branch |
| rs_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and a resolve can fall in the same cycle and hit the same entry. The loop traces provoke this on purpose by predicting and resolving each event in one cycle. Random traffic, with PCs drawn from a small set, repeats it many times. The judge is a behavioural model that computes each prediction from the table state before that cycle's resolve. The model applies the resolve only after the clock edge, so a design that forwards the new value is caught.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   typedef enum logic [2:0] {
      BDP_FALL = 3'd0,
      BDP_JUMP = 3'd1,
      BDP_BACK = 3'd2,
      BDP_LAST = 3'd3,
      BDP_HYST = 3'd4
   } bdp_mode_e;

   localparam int unsigned BDP_CTR_W = 2;
endpackage

// File: rtl/bdp_ctr_next.sv
module bdp_ctr_next #(
   parameter int unsigned W = 2
) (
   input  logic [W-1:0] cur_i,
   input  logic         taken_i,
   input  logic         last_mode_i,
   output logic [W-1:0] nxt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] BOT = '0;

   always_comb begin
      if (last_mode_i)
         nxt_o = {W{taken_i}};
      else if (taken_i)
         nxt_o = (cur_i == TOP) ? TOP : cur_i + 1'b1;
      else
         nxt_o = (cur_i == BOT) ? BOT : cur_i - 1'b1;
   end
endmodule

// File: rtl/bdp_table.sv
module bdp_table #(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx_i,
   output logic [W-1:0]     rd_a_q_o,
   input  logic [IDX_W-1:0] rd_b_idx_i,
   output logic [W-1:0]     rd_b_q_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [W-1:0]     wr_d_i
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [W-1:0] ent_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q[g] <= '0;
         else if (wr_en_i && wr_idx_i == IDX_W'(g))
            ent_q[g] <= wr_d_i;
      end
   end

   assign rd_a_q_o = ent_q[rd_a_idx_i];
   assign rd_b_q_o = ent_q[rd_b_idx_i];
endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
   import bdp_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      mode_i,
   input  logic [PC_W-1:0] lk_pc_i,
   input  logic [PC_W-1:0] lk_target_i,
   output logic            pred_taken_o,
   output logic [PC_W-1:0] next_pc_o,
   input  logic            rs_valid_i,
   input  logic [PC_W-1:0] rs_pc_i,
   input  logic            rs_taken_i
);
   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

   initial begin
      if (IDX_W < 1 || IDX_W > 12)
         $error("IDX_W must lie in 1..12");
      if (PC_W < IDX_HI + 1)
         $error("PC_W too narrow for the index field");
   end

   bdp_mode_e mode;
   assign mode = bdp_mode_e'(mode_i);

   logic [IDX_W-1:0]     lk_idx, rs_idx;
   logic [BDP_CTR_W-1:0] lk_ent, rs_ent, rs_nxt;
   logic                 is_last, wr_en;

   assign lk_idx  = lk_pc_i[IDX_HI:IDX_LO];
   assign rs_idx  = rs_pc_i[IDX_HI:IDX_LO];
   assign is_last = (mode == BDP_LAST);
   assign wr_en   = rs_valid_i && (mode == BDP_LAST || mode == BDP_HYST);

   bdp_table #(.IDX_W(IDX_W), .W(BDP_CTR_W)) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a_idx_i (lk_idx),
      .rd_a_q_o   (lk_ent),
      .rd_b_idx_i (rs_idx),
      .rd_b_q_o   (rs_ent),
      .wr_en_i    (wr_en),
      .wr_idx_i   (rs_idx),
      .wr_d_i     (rs_nxt)
   );

   bdp_ctr_next #(.W(BDP_CTR_W)) u_nxt (
      .cur_i       (rs_ent),
      .taken_i     (rs_taken_i),
      .last_mode_i (is_last),
      .nxt_o       (rs_nxt)
   );

   always_comb begin
      case (mode)
         BDP_JUMP: pred_taken_o = 1'b1;
         BDP_BACK: pred_taken_o = (lk_target_i < lk_pc_i);
         BDP_LAST,
         BDP_HYST: pred_taken_o = lk_ent[BDP_CTR_W-1];
         default:  pred_taken_o = 1'b0;
      endcase
   end

   assign next_pc_o = pred_taken_o ? lk_target_i : lk_pc_i + PC_W'(4);
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      mode_i,
   input logic [PC_W-1:0] lk_pc_i,
   input logic [PC_W-1:0] lk_target_i,
   input logic            pred_taken_o,
   input logic [PC_W-1:0] next_pc_o,
   input logic            rs_valid_i,
   input logic [PC_W-1:0] rs_pc_i,
   input logic            rs_taken_i
);
   a_r1_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0) |-> (!pred_taken_o && next_pc_o == lk_pc_i + PC_W'(4)));

   a_r2_always_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd1) |-> (pred_taken_o && next_pc_o == lk_target_i));

   a_r3_backward_rule: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd2) |-> (pred_taken_o == (lk_target_i < lk_pc_i)));

   a_r10_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc_o == (pred_taken_o ? lk_target_i : lk_pc_i + PC_W'(4)));

   a_r5_last_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_i == 3'd3 && rs_valid_i && rs_pc_i == lk_pc_i)
       && mode_i == 3'd3 && $stable(lk_pc_i))
      |-> (pred_taken_o == $past(rs_taken_i)));

   a_r6_strong_stays: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_i == 3'd4 && rs_valid_i && rs_taken_i
                              && rs_pc_i == lk_pc_i && pred_taken_o)
       && mode_i == 3'd4 && $stable(lk_pc_i))
      |-> pred_taken_o);
endmodule

bind bdir_predictor bdp_checker #(.PC_W(PC_W)) u_bdp_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .lk_pc_i      (lk_pc_i),
   .lk_target_i  (lk_target_i),
   .pred_taken_o (pred_taken_o),
   .next_pc_o    (next_pc_o),
   .rs_valid_i   (rs_valid_i),
   .rs_pc_i      (rs_pc_i),
   .rs_taken_i   (rs_taken_i)
);

// File: tb/tb_bdir_predictor.sv
module tb_bdir_predictor;
   localparam int unsigned PC_W  = 32;
   localparam int unsigned IDX_W = 6;
   localparam int unsigned N     = 1 << IDX_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      mode_i = 3'd0;
   logic [PC_W-1:0] lk_pc_i = '0, lk_target_i = '0, rs_pc_i = '0;
   logic            rs_valid_i = 1'b0, rs_taken_i = 1'b0;
   logic            pred_taken_o;
   logic [PC_W-1:0] next_pc_o;

   int checks = 0, errors = 0;
   int tbl [N];
   bit done = 0;

   always #4 clk = ~clk;

   bdir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lk_pc_i(lk_pc_i),
      .lk_target_i(lk_target_i), .pred_taken_o(pred_taken_o),
      .next_pc_o(next_pc_o), .rs_valid_i(rs_valid_i), .rs_pc_i(rs_pc_i),
      .rs_taken_i(rs_taken_i));

   function automatic int ix(logic [PC_W-1:0] pc);
      return int'((pc >> 2) & (N - 1));
   endfunction

   function automatic bit model_pred(logic [2:0] m, logic [PC_W-1:0] pc,
                                     logic [PC_W-1:0] tg);
      case (m)
         3'd1: return 1'b1;
         3'd2: return tg < pc;
         3'd3, 3'd4: return tbl[ix(pc)] >= 2;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare outputs, model update after posedge.
   task automatic step(input logic [2:0] m, input logic [PC_W-1:0] pc,
                       input logic [PC_W-1:0] tg, input bit rv,
                       input logic [PC_W-1:0] rpc, input bit rt,
                       input string req, output bit got);
      bit exp_p;
      logic [PC_W-1:0] exp_n;
      @(negedge clk);
      mode_i = m; lk_pc_i = pc; lk_target_i = tg;
      rs_valid_i = rv; rs_pc_i = rpc; rs_taken_i = rt;
      #2;
      exp_p = model_pred(m, pc, tg);
      exp_n = exp_p ? tg : pc + 4;
      check(pred_taken_o == exp_p, req, "pred", pred_taken_o, exp_p);
      check(next_pc_o == exp_n, "R10", "next_pc", next_pc_o, exp_n);
      got = pred_taken_o;
      @(posedge clk);
      if (rv && m == 3'd3) tbl[ix(rpc)] = rt ? 3 : 0;
      else if (rv && m == 3'd4) begin
         if (rt && tbl[ix(rpc)] < 3) tbl[ix(rpc)]++;
         else if (!rt && tbl[ix(rpc)] > 0) tbl[ix(rpc)]--;
      end
   endtask

   task automatic loop_pass(input logic [2:0] m, input logic [PC_W-1:0] pc,
                            output int correct);
      bit p;
      correct = 0;
      for (int e = 0; e < 5; e++) begin
         bit o = (e < 4);
         step(m, pc, pc - 32'h40, 1'b1, pc, o, "R8", p);
         if (p == o) correct++;
      end
   endtask

   task automatic look(input logic [2:0] m, input logic [PC_W-1:0] pc,
                       input string req, output bit p);
      step(m, pc, pc + 32'h100, 1'b0, '0, 1'b0, req, p);
   endtask

   initial begin
      bit p;
      int c;
      for (int i = 0; i < N; i++) tbl[i] = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R7: reset state in both dynamic modes
      for (int i = 0; i < 8; i++) begin
         look(3'd4, 32'h1000 + i * 4, "R7", p);
         look(3'd3, 32'h2000 + i * 8, "R7", p);
      end

      // R1, R2, R3 static schemes, including unused codes
      look(3'd0, 32'h300, "R1", p);
      look(3'd6, 32'h304, "R1", p);
      look(3'd1, 32'h308, "R2", p);
      step(3'd2, 32'h00A0, 32'h0040, 1'b0, '0, 1'b0, "R3", p);
      check(p == 1'b1, "R3", "backward taken", p, 1);
      step(3'd2, 32'h00A0, 32'h00A0, 1'b0, '0, 1'b0, "R3", p);
      check(p == 1'b0, "R3", "equal target", p, 0);
      step(3'd2, 32'h00A0, 32'h0100, 1'b0, '0, 1'b0, "R3", p);

      // R11/R5: last-outcome loop from reset
      loop_pass(3'd3, 32'h0400, c);
      check(c == 3, "R11", "one-bit correct", c, 3);
      // R11/R6: counter loop from reset, then second pass
      loop_pass(3'd4, 32'h0500, c);
      check(c == 2, "R11", "two-bit first pass", c, 2);
      loop_pass(3'd4, 32'h0500, c);
      check(c == 4, "R11", "two-bit second pass", c, 4);

      // R6 saturation at 00 and 11
      for (int i = 0; i < 5; i++) step(3'd4, 32'h600, 32'h0, 1'b1, 32'h600, 1'b1, "R6", p);
      step(3'd4, 32'h600, 32'h0, 1'b1, 32'h600, 1'b0, "R6", p);
      look(3'd4, 32'h600, "R6", p);
      check(p == 1'b1, "R6", "after saturating high, one NT", p, 1);
      for (int i = 0; i < 5; i++) step(3'd4, 32'h600, 32'h0, 1'b1, 32'h600, 1'b0, "R6", p);
      step(3'd4, 32'h600, 32'h0, 1'b1, 32'h600, 1'b1, "R6", p);
      look(3'd4, 32'h600, "R6", p);
      check(p == 1'b0, "R6", "after saturating low, one T", p, 0);

      // R4: alias across upper PC bits
      step(3'd3, 32'h0000_0710, 32'h0, 1'b1, 32'h0000_0710, 1'b1, "R4", p);
      look(3'd3, 32'h0001_0710, "R4", p);
      check(p == 1'b1, "R4", "aliased entry", p, 1);

      // R9: static-mode resolves do not write; mode switch keeps table
      step(3'd0, 32'h800, 32'h0, 1'b1, 32'h800, 1'b1, "R9", p);
      step(3'd2, 32'h800, 32'h0, 1'b1, 32'h800, 1'b1, "R9", p);
      step(3'd7, 32'h800, 32'h0, 1'b1, 32'h800, 1'b1, "R9", p);
      look(3'd4, 32'h800, "R9", p);
      check(p == 1'b0, "R9", "static resolve ignored", p, 0);
      look(3'd3, 32'h0710, "R9", p);
      check(p == 1'b1, "R9", "table kept over mode change", p, 1);
      // R5 writes both bits: taken in 1-bit mode reads strong in 2-bit mode
      step(3'd3, 32'h900, 32'h0, 1'b1, 32'h900, 1'b1, "R5", p);
      step(3'd4, 32'h900, 32'h0, 1'b1, 32'h900, 1'b0, "R5", p);
      look(3'd4, 32'h900, "R5", p);
      check(p == 1'b1, "R5", "replicated bits", p, 1);

      // Random traffic, compared every cycle
      for (int i = 0; i < 600; i++) begin
         logic [PC_W-1:0] a = 32'h2000 + 4 * ($urandom % 6);
         logic [PC_W-1:0] b = ($urandom % 2) ? a : 32'h2000 + 4 * ($urandom % 6);
         step(3'($urandom % 8), a, 32'h2000 + 4 * ($urandom % 8),
              1'($urandom), b, 1'($urandom), "R8", p);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule